// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block holds an 8-bit accumulator, a second data register and three status flags (carry, signed overflow, nibble carry). Each operation is started by a one-cycle strobe. It combines the accumulator with an 8-bit operand from the surrounding datapath and writes the result back into the accumulator. The operations cover loads, add and subtract with carry or borrow, increment and decrement, bitwise logic, clear, complement, nibble swap, and four rotates.

Most operations finish at the clock edge that accepts the strobe. Unsigned multiply and divide of the accumulator by the second register run as an iterative shift-add or shift-subtract loop over one cycle per bit. While that loop runs, the block reports busy. When it finishes, the block writes the two result bytes into the accumulator and the second register together. Every operation ends with a one-cycle done pulse.

Top module: `acc_alu`

## Requirements
- R1: After reset, acc_o, b_o, cy_o, ov_o, ac_o, busy_o and done_o are all 0.
- R2: Code 0 loads operand_i into the accumulator and code 1 loads it into the second register. Neither touches a flag. Codes 19 to 31 change no register or flag but still give a done pulse.
- R3: Code 2 (add) writes A+operand and code 3 (add with carry) writes A+operand+carry. Carry takes the carry out of bit 7 and the nibble flag takes the carry out of bit 3.
- R4: Code 4 (subtract with borrow) writes A-operand-carry. Carry is set exactly when operand+carry exceeds A. The nibble flag takes the borrow out of bit 3.
- R5: Codes 2, 3 and 4 set the overflow flag exactly when the two's-complement result falls outside -128..127.
- R6: Code 5 increments A (FFh wraps to 00h) and code 6 decrements A (00h wraps to FFh). All flags are left unchanged.
- R7: Codes 7, 8 and 9 write A AND, OR and XOR the operand. Code 10 clears A, code 11 inverts all bits of A, and code 12 exchanges the two nibbles of A. All flags are left unchanged.
- R8: Code 13 rotates A left with bit 7 entering bit 0. Code 14 rotates A right with bit 0 entering bit 7. Carry is unchanged.
- R9: Code 15 rotates left through carry: bit 7 goes to carry and the old carry to bit 0. Code 16 rotates right through carry: bit 0 goes to carry and the old carry to bit 7.
- R10: Code 17 multiplies A by B as unsigned numbers and writes the low byte to A and the high byte to B. It clears carry and sets overflow exactly when the high byte is non-zero.
- R11: Code 18 divides A by B as unsigned numbers, writing the quotient to A and the remainder to B, and clears carry and overflow. With B equal to 0, A and B keep their values, carry clears and overflow sets.
- R12: Every code except 17 and 18 updates the outputs, with done_o high, one cycle after the accepted strobe. Codes 17 and 18 keep busy_o high and A and B stable, and deliver the result with done_o ten cycles after the strobe.
- R13: A strobe that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code, sampled with the strobe |
| operand_i | input | 8 | Second operand, sampled with the strobe |
| start_i | input | 1 | Operation strobe |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | Second register |
| cy_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| ac_o | output | 1 | Nibble carry flag |
| busy_o | output | 1 | Multiply or divide in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The properties assume that op_i is only meaningful in a cycle where start_i is high and busy_o is low. They also assume the only way to leave a long operation is through its normal end, so no reset pulse occurs partway through a multiply or divide. The bench drives each strobe for a single cycle and waits for done_o before issuing the next. The one exception is a deliberate mid-multiply strobe, which is aimed at the busy window where it must be discarded. Random codes include the unused range, and random operands often leave B at zero, so the divide-by-zero path is reached without a dedicated directive.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LDA  = 5'd0,
    OP_LDB  = 5'd1,
    OP_ADD  = 5'd2,
    OP_ADDC = 5'd3,
    OP_SUBB = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_CLR  = 5'd10,
    OP_CPL  = 5'd11,
    OP_SWAP = 5'd12,
    OP_RL   = 5'd13,
    OP_RR   = 5'd14,
    OP_RLC  = 5'd15,
    OP_RRC  = 5'd16,
    OP_MUL  = 5'd17,
    OP_DIV  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   opd_i,
  input  logic           cy_i,
  input  logic           ov_i,
  input  logic           ac_i,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o,
  output logic           cy_o,
  output logic           ov_o,
  output logic           ac_o
);
  localparam int unsigned N = W / 2;

  logic         cin;
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [N:0]   hsum;
  logic [N:0]   hdiff;
  logic         add_ov;
  logic         sub_ov;
  logic [W-1:0] swapped;

  assign cin   = (op_i == OP_ADDC) & cy_i;
  assign sum   = {1'b0, a_i} + {1'b0, opd_i} + {{W{1'b0}}, cin};
  assign hsum  = {1'b0, a_i[N-1:0]} + {1'b0, opd_i[N-1:0]} + {{N{1'b0}}, cin};
  // borrow lands in the extra top bit
  assign diff  = {1'b0, a_i} - {1'b0, opd_i} - {{W{1'b0}}, cy_i};
  assign hdiff = {1'b0, a_i[N-1:0]} - {1'b0, opd_i[N-1:0]} - {{N{1'b0}}, cy_i};

  assign add_ov = (a_i[W-1] == opd_i[W-1]) && (sum[W-1] != a_i[W-1]);
  assign sub_ov = (a_i[W-1] != opd_i[W-1]) && (diff[W-1] != a_i[W-1]);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_swap
      assign swapped[gi]   = a_i[gi+N];
      assign swapped[gi+N] = a_i[gi];
    end
  endgenerate

  always_comb begin
    a_o  = a_i;
    b_o  = b_i;
    cy_o = cy_i;
    ov_o = ov_i;
    ac_o = ac_i;
    case (op_i)
      OP_LDA: a_o = opd_i;
      OP_LDB: b_o = opd_i;
      OP_ADD, OP_ADDC: begin
        a_o  = sum[W-1:0];
        cy_o = sum[W];
        ac_o = hsum[N];
        ov_o = add_ov;
      end
      OP_SUBB: begin
        a_o  = diff[W-1:0];
        cy_o = diff[W];
        ac_o = hdiff[N];
        ov_o = sub_ov;
      end
      OP_INC:  a_o = a_i + 1'b1;
      OP_DEC:  a_o = a_i - 1'b1;
      OP_AND:  a_o = a_i & opd_i;
      OP_OR:   a_o = a_i | opd_i;
      OP_XOR:  a_o = a_i ^ opd_i;
      OP_CLR:  a_o = '0;
      OP_CPL:  a_o = ~a_i;
      OP_SWAP: a_o = swapped;
      OP_RL:   a_o = {a_i[W-2:0], a_i[W-1]};
      OP_RR:   a_o = {a_i[0], a_i[W-1:1]};
      OP_RLC: begin
        a_o  = {a_i[W-2:0], cy_i};
        cy_o = a_i[W-1];
      end
      OP_RRC: begin
        a_o  = {cy_i, a_i[W-1:1]};
        cy_o = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         is_div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_o,
  output logic         divz_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             busy_q, done_q, div_q, divz_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     hi_q, lo_q, dvs_q;

  // multiply step: conditional add, then shift right
  logic [W:0]   addv;
  // divide step: shift left, trial subtract
  logic [W:0]   shv, subv;
  logic         ge;
  logic [W-1:0] hi_n, lo_n;

  assign addv = {1'b0, hi_q} + (lo_q[0] ? {1'b0, dvs_q} : {(W+1){1'b0}});
  assign shv  = {hi_q, lo_q[W-1]};
  assign subv = shv - {1'b0, dvs_q};
  assign ge   = shv >= {1'b0, dvs_q};

  always_comb begin
    if (div_q) begin
      hi_n = ge ? subv[W-1:0] : shv[W-1:0];
      lo_n = {lo_q[W-2:0], ge};
    end else begin
      hi_n = addv[W:1];
      lo_n = {addv[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= 1'b0;
      divz_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      dvs_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      div_q  <= is_div_i;
      divz_q <= is_div_i && (b_i == '0);
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= a_i;
      dvs_q  <= b_i;
    end else if (busy_q) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign div_o  = div_q;
  assign divz_o = divz_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    operand_i,
  input  logic            start_i,
  output logic [W-1:0]    acc_o,
  output logic [W-1:0]    b_o,
  output logic            cy_o,
  output logic            ov_o,
  output logic            ac_o,
  output logic            busy_o,
  output logic            done_o
);
  alu_op_e      op_e;
  logic         accept, is_md;
  logic [W-1:0] a_q, b_q;
  logic         cy_q, ov_q, ac_q, done_q;

  logic [W-1:0] lg_a, lg_b;
  logic         lg_cy, lg_ov, lg_ac;

  logic         md_busy, md_done, md_div, md_divz;
  logic [W-1:0] md_hi, md_lo;

  assign op_e   = alu_op_e'(op_i);
  assign is_md  = (op_e == OP_MUL) || (op_e == OP_DIV);
  assign busy_o = md_busy | md_done;
  assign accept = start_i & ~busy_o;

  acc_alu_logic #(.W(W)) u_logic (
    .op_i (op_e),
    .a_i  (a_q),
    .b_i  (b_q),
    .opd_i(operand_i),
    .cy_i (cy_q),
    .ov_i (ov_q),
    .ac_i (ac_q),
    .a_o  (lg_a),
    .b_o  (lg_b),
    .cy_o (lg_cy),
    .ov_o (lg_ov),
    .ac_o (lg_ac)
  );

  acc_alu_muldiv #(.W(W)) u_muldiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept & is_md),
    .is_div_i(op_e == OP_DIV),
    .a_i     (a_q),
    .b_i     (b_q),
    .busy_o  (md_busy),
    .done_o  (md_done),
    .div_o   (md_div),
    .divz_o  (md_divz),
    .hi_o    (md_hi),
    .lo_o    (md_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      ac_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (md_done) begin
        done_q <= 1'b1;
        cy_q   <= 1'b0;
        if (md_divz) begin
          ov_q <= 1'b1;
        end else begin
          a_q  <= md_lo;
          b_q  <= md_hi;
          ov_q <= md_div ? 1'b0 : (md_hi != '0);
        end
      end else if (accept && !is_md) begin
        a_q    <= lg_a;
        b_q    <= lg_b;
        cy_q   <= lg_cy;
        ov_q   <= lg_ov;
        ac_q   <= lg_ac;
        done_q <= 1'b1;
      end
    end
  end

  assign acc_o  = a_q;
  assign b_o    = b_q;
  assign cy_o   = cy_q;
  assign ov_o   = ov_q;
  assign ac_o   = ac_q;
  assign done_o = done_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic            start_i,
  input logic [W-1:0]    acc_o,
  input logic [W-1:0]    b_o,
  input logic            cy_o,
  input logic            ov_o,
  input logic            busy_o,
  input logic            done_o
);
  logic         md_div_q;
  logic [W-1:0] md_dvs_q;
  logic         md_go;

  assign md_go = start_i && !busy_o &&
                 ((op_i == OP_MUL) || (op_i == OP_DIV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      md_div_q <= 1'b0;
      md_dvs_q <= '0;
    end else if (md_go) begin
      md_div_q <= (op_i == OP_DIV);
      md_dvs_q <= b_o;
    end
  end

  // R6
  incdec_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ((op_i == OP_INC) || (op_i == OP_DEC)))
      |=> (cy_o == $past(cy_o)));

  // R10
  md_carry_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && !cy_o));

  // R10
  mul_ov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !md_div_q) |-> (ov_o == (b_o != '0)));

  // R11
  div_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && md_div_q && !ov_o) |-> (b_o < md_dvs_q));

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(acc_o) && $stable(b_o)));

  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .start_i(start_i),
  .acc_o  (acc_o),
  .b_o    (b_o),
  .cy_o   (cy_o),
  .ov_o   (ov_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       start_i = 1'b0;
  logic [7:0] acc_o, b_o;
  logic       cy_o, ov_o, ac_o, busy_o, done_o;

  int n_tests = 0;
  int n_fail = 0;
  int ma = 0, mb = 0, mc = 0, mv = 0, mh = 0;

  always #2.5 clk_i = ~clk_i;

  acc_alu u_acc_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .operand_i(operand_i),
    .start_i(start_i), .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o),
    .ac_o(ac_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      2, 3:                 return "R3";
      4:                    return "R4";
      5, 6:                 return "R6";
      7, 8, 9, 10, 11, 12:  return "R7";
      13, 14:               return "R8";
      15, 16:               return "R9";
      17:                   return "R10";
      18:                   return "R11";
      default:              return "R2";
    endcase
  endfunction

  // reference model of the requirements
  task automatic model(input int op, input int opd);
    int s, hs, cin;
    case (op)
      0: ma = opd;
      1: mb = opd;
      2, 3: begin
        cin = (op == 3) ? mc : 0;
        s  = ma + opd + cin;
        hs = (ma & 15) + (opd & 15) + cin;
        mv = (((ma ^ s) & (opd ^ s) & 128) != 0) ? 1 : 0;
        mc = (s > 255) ? 1 : 0;
        mh = (hs > 15) ? 1 : 0;
        ma = s & 255;
      end
      4: begin
        s  = ma - opd - mc;
        hs = (ma & 15) - (opd & 15) - mc;
        mv = (((ma ^ opd) & (ma ^ s) & 128) != 0) ? 1 : 0;
        mc = (s < 0) ? 1 : 0;
        mh = (hs < 0) ? 1 : 0;
        ma = s & 255;
      end
      5:  ma = (ma + 1) & 255;
      6:  ma = (ma + 255) & 255;
      7:  ma = ma & opd;
      8:  ma = ma | opd;
      9:  ma = ma ^ opd;
      10: ma = 0;
      11: ma = 255 - ma;
      12: ma = ((ma & 15) << 4) | (ma >> 4);
      13: ma = ((ma << 1) & 255) | (ma >> 7);
      14: ma = (ma >> 1) | ((ma & 1) << 7);
      15: begin s = ma >> 7; ma = ((ma << 1) & 255) | mc; mc = s; end
      16: begin s = ma & 1; ma = (ma >> 1) | (mc << 7); mc = s; end
      17: begin
        s = ma * mb; ma = s & 255; mb = s >> 8;
        mc = 0; mv = (mb != 0) ? 1 : 0;
      end
      18: begin
        mc = 0;
        if (mb == 0) mv = 1;
        else begin s = ma / mb; mb = ma % mb; ma = s; mv = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic compare(input int op);
    string t = tag_of(op);
    string tv = (op >= 2 && op <= 4) ? "R5" : t;
    check(acc_o == 8'(ma), t, acc_o, ma);
    check(b_o == 8'(mb), t, b_o, mb);
    check(cy_o == 1'(mc), t, cy_o, mc);
    check(ov_o == 1'(mv), tv, ov_o, mv);
    check(ac_o == 1'(mh), t, ac_o, mh);
  endtask

  task automatic do_op(input int op, input int opd);
    int lat;
    int exp_lat;
    @(negedge clk_i);
    op_i = 5'(op); operand_i = 8'(opd); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin @(negedge clk_i); lat++; end
    exp_lat = (op == 17 || op == 18) ? 10 : 1;
    check(lat == exp_lat, "R12", lat, exp_lat); // R12 latency
    model(op, opd);
    compare(op);
  endtask

  initial begin
    #500000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int op, cnt_done;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check({acc_o, b_o, cy_o, ov_o, ac_o, busy_o, done_o} == '0, "R1",
          {acc_o, b_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({acc_o, b_o, cy_o, ov_o, ac_o, busy_o, done_o} == '0, "R1",
          {acc_o, b_o}, 0);

    // directed corners
    do_op(0, 8'h7F); do_op(2, 8'h01);            // R5 signed overflow on add
    do_op(2, 8'h80);                             // R3 carry out
    do_op(3, 8'h0F);                             // R3 add with carry, nibble carry
    do_op(0, 8'h10); do_op(4, 8'h20);            // R4 borrow
    do_op(4, 8'h01);                             // R4 with borrow in
    do_op(0, 8'h80); do_op(4, 8'h01);            // R5 overflow on subtract
    do_op(0, 8'hFF); do_op(5, 0);                // R6 increment wrap
    do_op(6, 0);                                 // R6 decrement wrap
    do_op(0, 8'hA5); do_op(12, 0); do_op(11, 0); // R7 swap, complement
    do_op(15, 0); do_op(16, 0); do_op(13, 0); do_op(14, 0); // R8 R9
    do_op(0, 8'hFF); do_op(1, 8'hFF); do_op(17, 0); // R10 max product
    do_op(0, 8'hC8); do_op(1, 8'h07); do_op(18, 0); // R11 divide
    do_op(1, 8'h00); do_op(18, 0);               // R11 divide by zero
    do_op(25, 8'h33);                            // R2 unused code

    // R13: strobe during multiply is ignored
    do_op(0, 8'h12); do_op(1, 8'h34);
    @(negedge clk_i);
    op_i = 5'd17; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    op_i = 5'd0; operand_i = 8'hEE; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    cnt_done = 0;
    repeat (12) begin @(negedge clk_i); if (done_o) cnt_done++; end
    model(17, 0);
    check(acc_o == 8'(ma), "R13", acc_o, ma);
    check(b_o == 8'(mb), "R13", b_o, mb);
    check(cnt_done == 1, "R13", cnt_done, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      op = $urandom_range(0, 20);
      if (op > 18) op = $urandom_range(19, 31);
      do_op(op, $urandom_range(0, 255));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule